// File: doc/BRIEF.md
# Four-Way CAN Acceptance Filter

This block sits between a CAN receiver and its receive buffer. It decides whether a received frame is kept. Each incoming frame is presented as a 32-bit identifier word, a 4-bit length code and a one-cycle valid strobe. One clock later the block returns a keep-or-drop verdict. The receive buffer stores the frame only when the verdict is "keep".

There are four filters. Each filter has a mask word and a reference word, and both use the same layout as the identifier word:
- bits 31:21 hold the base ID,
- bit 20 holds the substitute-remote flag,
- bit 19 holds the extended-format flag,
- bits 18:1 hold the extended ID,
- bit 0 holds the remote flag.

A filter matches when the identifier word and the reference word agree on every bit that is set in the mask.

Software loads the filters through a simple 32-bit write port. The same port writes a 4-bit enable word, one bit per filter. A filter's mask and reference words are locked while that filter is enabled. Software therefore disables a filter, reprograms it, and enables it again. A status output reports when all four filters are enabled at once.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, every filter is disabled, every mask and reference word is 0, `acc_valid` and `acc_pass` are 0, and `filt_busy` is 0.
- R2: While all four enable bits are 0, every frame with a length code of 8 or less is kept, whatever its identifier.
- R3: Filter n matches when (mask_n AND identifier) equals (mask_n AND reference_n). The words use the layout base ID [31:21], substitute-remote [20], extended flag [19], extended ID [18:1], remote [0].
- R4: While at least one filter is enabled, a frame is kept if any enabled filter matches, whichever filter that is.
- R5: While at least one filter is enabled, a frame that no enabled filter matches is dropped. A disabled filter never causes a frame to be kept.
- R6: A write to a filter's mask or reference word while that filter's enable bit is 1 is discarded, and the old value stays.
- R7: A write to a filter's mask or reference word while its enable bit is 0 takes effect and is used for the next frame.
- R8: `filt_busy` is 1 exactly when all four enable bits are 1. It reflects the enable word from the cycle after the write.
- R9: A frame whose length code is greater than 8 is always dropped.
- R10: `acc_valid` is 1 in exactly the cycle after the cycle in which `id_valid` is 1. `acc_pass` is 0 whenever `acc_valid` is 0.
- R11: The register map is as follows:
  - The enable word is at 0x60. Bit k of the enable word enables filter k+1, and bits 31:4 are ignored.
  - Filter k+1 has its mask word at 0x64+8k and its reference word at 0x68+8k.
  - A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| id_valid | input | 1 | Frame present this cycle |
| id_word | input | 32 | Frame identifier word |
| id_dlc | input | 4 | Frame length code |
| acc_valid | output | 1 | Verdict valid (one cycle after `id_valid`) |
| acc_pass | output | 1 | 1 = keep the frame, 0 = drop it |
| filt_busy | output | 1 | All four filters enabled |

## Verification
The hardest situation to reach from the ports is a locked write. There is no readback path, so a discarded write to a mask or reference word can be seen only through later verdicts. The stimulus first programs a filter while it is disabled and then enables it. It then writes a different reference word to that filter and sends frames that only the new value would keep. The frame is dropped if the lock held. Finally the filter is disabled and the same write is repeated. The changed verdict then proves that the write path itself works.

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int NF       = 4,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int EN_ADDR  = 'h60,
  parameter int DLC_MAX  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          id_valid,
  input  logic [DW-1:0] id_word,
  input  logic [3:0]    id_dlc,
  output logic          acc_valid,
  output logic          acc_pass,
  output logic          filt_busy
);

  localparam logic [AW-1:0] EN_A = AW'(EN_ADDR);

  logic [NF-1:0]         en_q;
  logic [NF-1:0][DW-1:0] mask_q;
  logic [NF-1:0][DW-1:0] idr_q;
  logic [NF-1:0]         hit;
  logic                  pass_c;

  always_ff @(posedge clk) begin
    if (!rst_n)                        en_q <= '0;
    else if (wr_en && wr_addr == EN_A) en_q <= wr_data[NF-1:0];
  end

  for (genvar g = 0; g < NF; g++) begin : g_filt
    localparam logic [AW-1:0] M_A = AW'(EN_ADDR + 4 + 8 * g);
    localparam logic [AW-1:0] I_A = AW'(EN_ADDR + 8 + 8 * g);
    logic [DW-1:0] m_q, i_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m_q <= '0;
        i_q <= '0;
      end else if (wr_en && !en_q[g]) begin
        if (wr_addr == M_A) m_q <= wr_data;
        if (wr_addr == I_A) i_q <= wr_data;
      end
    end

    assign mask_q[g] = m_q;
    assign idr_q[g]  = i_q;
    assign hit[g]    = en_q[g] && ((m_q & id_word) == (m_q & i_q));
  end

  assign pass_c    = ((en_q == '0) || (|hit)) && (id_dlc <= 4'(DLC_MAX));
  assign filt_busy = &en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_pass  <= 1'b0;
    end else begin
      acc_valid <= id_valid;
      acc_pass  <= id_valid && pass_c;
    end
  end

endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NF      = 4,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int EN_ADDR = 'h60,
  parameter int DLC_MAX = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [AW-1:0]         wr_addr,
  input logic [NF-1:0]         wr_low,
  input logic                  id_valid,
  input logic [3:0]            id_dlc,
  input logic                  acc_valid,
  input logic                  acc_pass,
  input logic                  filt_busy,
  input logic [NF-1:0]         en_q,
  input logic [NF-1:0][DW-1:0] mask_q,
  input logic [NF-1:0][DW-1:0] idr_q
);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> acc_valid);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> !acc_valid && !acc_pass);

  // R9
  long_dlc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && id_dlc > 4'(DLC_MAX) |=> !acc_pass);

  // R2
  open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && en_q == '0 && id_dlc <= 4'(DLC_MAX) |=> acc_pass);

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == AW'(EN_ADDR) |=> filt_busy == (&$past(wr_low)));

  for (genvar g = 0; g < NF; g++) begin : g_lock
    // R6
    mask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && en_q[g] && wr_addr == AW'(EN_ADDR + 4 + 8 * g) |=> $stable(mask_q[g]));
    // R6
    id_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && en_q[g] && wr_addr == AW'(EN_ADDR + 8 + 8 * g) |=> $stable(idr_q[g]));
  end

endmodule

bind can_accept_filter can_accept_filter_chk #(
  .NF(NF), .DW(DW), .AW(AW), .EN_ADDR(EN_ADDR), .DLC_MAX(DLC_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_low(wr_data[NF-1:0]), .id_valid(id_valid), .id_dlc(id_dlc),
  .acc_valid(acc_valid), .acc_pass(acc_pass), .filt_busy(filt_busy),
  .en_q(en_q), .mask_q(mask_q), .idr_q(idr_q)
);

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        id_valid = 1'b0;
  logic [31:0] id_word = '0;
  logic [3:0]  id_dlc = '0;
  logic        acc_valid, acc_pass, filt_busy;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  can_accept_filter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .id_valid(id_valid), .id_word(id_word), .id_dlc(id_dlc),
    .acc_valid(acc_valid), .acc_pass(acc_pass), .filt_busy(filt_busy)
  );

  function automatic logic [31:0] base(input logic [10:0] b);
    return {b, 21'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frame(input logic [31:0] w, input logic [3:0] dlc, input bit exp, input string req);
    @(negedge clk);
    id_valid = 1'b1; id_word = w; id_dlc = dlc;
    @(negedge clk);
    id_valid = 1'b0;
    chk(acc_valid === 1'b1, req, int'(acc_valid), 1);
    chk(acc_pass === exp, req, int'(acc_pass), int'(exp));
  endtask

  task automatic t_reset;
    chk(acc_valid === 1'b0 && acc_pass === 1'b0, "R1", int'({acc_valid, acc_pass}), 0);
    chk(filt_busy === 1'b0, "R1", int'(filt_busy), 0);
  endtask

  task automatic t_open;
    frame(base(11'h7FF) | 32'h0008_0001, 4'd8, 1'b1, "R2");
    frame(32'h0, 4'd0, 1'b1, "R2");
    frame(base(11'h123), 4'd9, 1'b0, "R9");
    frame(base(11'h123), 4'd15, 1'b0, "R9");
    @(negedge clk);
    chk(acc_valid === 1'b0 && acc_pass === 1'b0, "R10", int'({acc_valid, acc_pass}), 0);
  endtask

  task automatic t_base_id;
    wr(8'h64, 32'hFFE0_0000);
    wr(8'h68, base(11'h123));
    wr(8'h60, 32'h1);
    frame(base(11'h123) | 32'h0003_FFFF, 4'd4, 1'b1, "R3");
    frame(base(11'h124), 4'd4, 1'b0, "R5");
    frame(base(11'h123), 4'd9, 1'b0, "R9");
  endtask

  task automatic t_ide_filter;
    wr(8'h6C, 32'h0008_0000);
    wr(8'h70, 32'h0008_0000);
    wr(8'h60, 32'h3);
    frame(base(11'h555) | 32'h0008_0000, 4'd8, 1'b1, "R4");
    frame(base(11'h555), 4'd8, 1'b0, "R5");
    frame(base(11'h123), 4'd8, 1'b1, "R4");
  endtask

  task automatic t_lock;
    wr(8'h68, base(11'h124));
    wr(8'h64, 32'h0);
    frame(base(11'h124), 4'd2, 1'b0, "R6");
    frame(base(11'h123), 4'd2, 1'b1, "R6");
    wr(8'h60, 32'h2);
    frame(base(11'h123), 4'd2, 1'b0, "R5");
    wr(8'h68, base(11'h124));
    wr(8'h60, 32'h3);
    frame(base(11'h124), 4'd2, 1'b1, "R7");
    frame(base(11'h123), 4'd2, 1'b0, "R7");
  endtask

  task automatic t_upper;
    wr(8'h74, 32'hFFFF_FFFF);
    wr(8'h78, 32'hA5A5_A5A5);
    wr(8'h7C, 32'hFFFF_FFFF);
    wr(8'h80, 32'h1234_5678);
    wr(8'h60, 32'h4);
    frame(32'hA5A5_A5A5, 4'd1, 1'b1, "R11");
    frame(32'hA5A5_A5A4, 4'd1, 1'b0, "R11");
    frame(32'h1234_5678, 4'd1, 1'b0, "R5");
    wr(8'h60, 32'h8);
    frame(32'h1234_5678, 4'd1, 1'b1, "R11");
    frame(32'hA5A5_A5A5, 4'd1, 1'b0, "R11");
  endtask

  task automatic t_busy;
    wr(8'h60, 32'h7);
    @(negedge clk);
    chk(filt_busy === 1'b0, "R8", int'(filt_busy), 0);
    wr(8'h60, 32'hF);
    chk(filt_busy === 1'b1, "R8", int'(filt_busy), 1);
    wr(8'h60, 32'hFFFF_FFF0);
    chk(filt_busy === 1'b0, "R8", int'(filt_busy), 0);
    frame(32'hDEAD_BEEF, 4'd3, 1'b1, "R11");
    wr(8'h5C, 32'hF);
    wr(8'h84, 32'hF);
    chk(filt_busy === 1'b0, "R11", int'(filt_busy), 0);
    frame(32'h0BAD_F00D, 4'd3, 1'b1, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open();
    t_base_id();
    t_ide_filter();
    t_lock();
    t_upper();
    t_busy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule